// File: doc/BRIEF.md
# Legacy PC System Control Ports

This block decodes a byte-wide I/O port bus and implements three small platform controls found on PC-compatible systems. A write to the delay port (address 0x80) is accepted and discarded; software uses it only to burn bus time. The system-control port (address 0x92) holds the address-line-20 gate. Bit 1 of a write opens or masks the gate, and a read returns the gate level in bit 1. The coprocessor-error clear port (address 0xF0) releases a latched floating-point error interrupt. Any write to it does this, whatever the data.

The block has two small state machines. The A20 gate machine has the states `GATE_MASKED` and `GATE_OPEN`. Transition `open` is a write to 0x92 with bit 1 set. Transition `mask` is a write to 0x92 with bit 1 clear. Any other cycle holds the state. The error-latch machine has the states `ERR_IDLE` and `ERR_RAISED`. Transition `raise` is taken whenever the error input is high, from either state. Transition `release` is a write to 0xF0 without a simultaneous error. Any other cycle holds the state. Reset places both machines in their first state.

Read data and a read-hit flag are registered and appear one clock after the read strobe. Only port 0x92 is readable. Bit 0 of port 0x92 is a reset request on real platforms; here it is ignored.

Top module: `legacy_sysctl_ports`

## Requirements
- R1: After reset `a20_en` is 0, `ferr_irq` is 0, `bus_rdata` is 0x00 and `bus_hit` is 0.
- R2: A write to address 0x92 sets `a20_en`, from the next clock edge, to bit 1 of `bus_wdata`.
- R3: A read of address 0x92 gives, one clock after the strobe, `bus_rdata` equal to `a20_en` (as it was in the strobe cycle) in bit 1, all other bits 0, with `bus_hit` = 1.
- R4: Bit 0 and bits 7..2 of a write to 0x92 have no effect: `a20_en` and the value read back depend only on bit 1.
- R5: A write to address 0x80 changes neither `a20_en` nor `ferr_irq`, whatever its data.
- R6: `fpu_err` high in a cycle makes `ferr_irq` high from the next edge; it stays high until released.
- R7: Any write to address 0xF0, whatever its data, drives `ferr_irq` low from the next edge when `fpu_err` is low in that cycle.
- R8: When `fpu_err` and a write to 0xF0 occur in the same cycle, `ferr_irq` is high afterwards.
- R9: A read of any address other than 0x92 (including 0x80 and 0xF0) gives `bus_rdata` = 0x00 and `bus_hit` = 0 one clock later.
- R10: A cycle without a read strobe gives `bus_rdata` = 0x00 and `bus_hit` = 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_hit | output | 1 | Registered flag: the last read matched a readable port |
| fpu_err | input | 1 | Floating-point error request from the core |
| a20_en | output | 1 | Address-line-20 gate enable |
| ferr_irq | output | 1 | Latched floating-point error interrupt |

## Verification
Directed cases first set bit 1 of port 0x92 alone, then bit 0 alone, then all bits. This separates a gate that follows bit 1 from one that follows bit 0 or any non-zero byte. Errors and clear writes are issued apart and then in the same cycle, which shows whether set has priority over clear. Reads of the write-only ports and of random addresses separate a full address compare from a partial one. A long random mix of reads, writes and error pulses, with some cycles reading and writing 0x92 together, is then compared against a cycle model kept in the bench.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    typedef enum logic {
        GATE_MASKED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_t;

    typedef enum logic {
        ERR_IDLE   = 1'b0,
        ERR_RAISED = 1'b1
    } err_state_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] DELAY_PORT = 16'h0080,
    parameter logic [15:0] GATE_PORT  = 16'h0092,
    parameter logic [15:0] CLEAR_PORT = 16'h00F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              gate_wr,
    output logic              gate_rd,
    output logic              clear_wr,
    output logic              delay_wr
);
    localparam logic [ADDR_W-1:0] DLY = ADDR_W'(DELAY_PORT);
    localparam logic [ADDR_W-1:0] GTE = ADDR_W'(GATE_PORT);
    localparam logic [ADDR_W-1:0] CLR = ADDR_W'(CLEAR_PORT);

    always_comb begin
        gate_wr  = wr && (addr == GTE);
        gate_rd  = rd && (addr == GTE);
        clear_wr = wr && (addr == CLR);
        delay_wr = wr && (addr == DLY);
    end
endmodule

// File: rtl/sysctl_a20_gate.sv
module sysctl_a20_gate
    import sysctl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GATE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              a20_en
);
    gate_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_MASKED: if (gate_wr && wdata[GATE_BIT])  state_d = GATE_OPEN;
            GATE_OPEN:   if (gate_wr && !wdata[GATE_BIT]) state_d = GATE_MASKED;
            default:     state_d = GATE_MASKED;
        endcase
    end

    always_comb a20_en = (state_q == GATE_OPEN);

    // R2: gate level follows bit 1 of the port write
    a_r2_gate_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        gate_wr |=> (a20_en == $past(wdata[GATE_BIT])));
    // R5: without a write to the gate port the level holds
    a_r5_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_wr |=> $stable(a20_en));
endmodule

// File: rtl/sysctl_err_latch.sv
module sysctl_err_latch
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_in,
    input  logic clear_wr,
    output logic irq
);
    err_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ERR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_IDLE:   if (err_in)                state_d = ERR_RAISED;
            ERR_RAISED: if (clear_wr && !err_in)   state_d = ERR_IDLE;
            default:    state_d = ERR_IDLE;
        endcase
    end

    always_comb irq = (state_q == ERR_RAISED);

    // R6: an error request raises the interrupt
    a_r6_err_raises: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> irq);
    // R6: a raised interrupt persists until a clear write
    a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear_wr) |=> irq);
    // R7: a clear write without a new error releases the interrupt
    a_r7_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && !err_in) |=> !irq);
    // R8: set wins over simultaneous clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && err_in) |=> irq);
endmodule

// File: rtl/legacy_sysctl_ports.sv
module legacy_sysctl_ports #(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          GATE_BIT   = 1,
    parameter logic [15:0] DELAY_PORT = 16'h0080,
    parameter logic [15:0] GATE_PORT  = 16'h0092,
    parameter logic [15:0] CLEAR_PORT = 16'h00F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    input  logic              fpu_err,
    output logic              a20_en,
    output logic              ferr_irq
);
    logic gate_wr, gate_rd, clear_wr, delay_wr;
    logic [DATA_W-1:0] rdata_d;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .DELAY_PORT(DELAY_PORT),
        .GATE_PORT(GATE_PORT), .CLEAR_PORT(CLEAR_PORT)
    ) u_decode (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .gate_wr(gate_wr), .gate_rd(gate_rd),
        .clear_wr(clear_wr), .delay_wr(delay_wr)
    );

    sysctl_a20_gate #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate_wr(gate_wr),
        .wdata(bus_wdata), .a20_en(a20_en)
    );

    sysctl_err_latch u_err (
        .clk(clk), .rst_n(rst_n), .err_in(fpu_err),
        .clear_wr(clear_wr), .irq(ferr_irq)
    );

    always_comb begin
        rdata_d = '0;
        rdata_d[GATE_BIT] = a20_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_hit   <= 1'b0;
        end else begin
            bus_rdata <= gate_rd ? rdata_d : '0;
            bus_hit   <= gate_rd;
        end
    end

    // R3: a gate-port read returns the gate level in its bit, one clock later
    a_r3_gate_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(GATE_PORT)) |=>
            (bus_hit && bus_rdata[GATE_BIT] == $past(a20_en)
             && $countones(bus_rdata) <= 1));
    // R9, R10: anything else leaves the read bus quiet
    a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == ADDR_W'(GATE_PORT)) |=> (!bus_hit && bus_rdata == '0));
    // R5: a delay-port write never disturbs the interrupt level
    a_r5_delay_no_irq_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_wr && !fpu_err) |=> (ferr_irq == $past(ferr_irq)));
endmodule

// File: tb/legacy_sysctl_ports_bench.sv
module legacy_sysctl_ports_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd, fpu_err;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_hit, a20_en, ferr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    bit       m_a20, m_ferr, m_hit;
    bit [7:0] m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_sysctl_ports u_legacy_sysctl_ports (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_hit(bus_hit), .fpu_err(fpu_err), .a20_en(a20_en),
        .ferr_irq(ferr_irq)
    );

    function automatic bit [7:0] read_value(bit [15:0] a, bit rd, bit a20);
        return (rd && a == 16'h0092) ? {6'b0, a20, 1'b0} : 8'h00;
    endfunction

    function automatic bit next_a20(bit [15:0] a, bit wr, bit [7:0] d, bit cur);
        return (wr && a == 16'h0092) ? d[1] : cur;
    endfunction

    function automatic bit next_ferr(bit [15:0] a, bit wr, bit err, bit cur);
        if (err) return 1'b1;
        if (wr && a == 16'h00F0) return 1'b0;
        return cur;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic compare(string r_a20, string r_ferr, string r_rd);
        check(a20_en == m_a20, r_a20, a20_en, m_a20);
        check(ferr_irq == m_ferr, r_ferr, ferr_irq, m_ferr);
        check(bus_rdata == m_rdata, r_rd, bus_rdata, m_rdata);
        check(bus_hit == m_hit, r_rd, bus_hit, m_hit);
    endtask

    // drive one cycle at the falling edge, update model, sample after the rising edge
    task automatic step(bit [15:0] a, bit wr, bit rd, bit [7:0] d, bit err);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d; fpu_err = err;
        m_rdata = read_value(a, rd, m_a20);
        m_hit   = rd && (a == 16'h0092);
        m_a20   = next_a20(a, wr, d, m_a20);
        m_ferr  = next_ferr(a, wr, err, m_ferr);
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; fpu_err = 0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; fpu_err = 0;
        m_a20 = 0; m_ferr = 0; m_hit = 0; m_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        compare("R1", "R1", "R1");

        // R2: write bit 1 opens gate
        step(16'h0092, 1, 0, 8'h02, 0); compare("R2", "R5", "R10");
        // R3: read back gate
        step(16'h0092, 0, 1, 8'h00, 0); compare("R3", "R6", "R3");
        // R4: bit 0 alone masks gate (bit 1 clear)
        step(16'h0092, 1, 0, 8'h01, 0); compare("R4", "R6", "R10");
        step(16'h0092, 0, 1, 8'h00, 0); compare("R4", "R6", "R4");
        // R4: all other bits set, bit 1 clear
        step(16'h0092, 1, 0, 8'hFD, 0); compare("R4", "R6", "R10");
        // R3: all bits set, read returns only bit 1
        step(16'h0092, 1, 0, 8'hFF, 0); compare("R2", "R6", "R10");
        step(16'h0092, 0, 1, 8'h00, 0); compare("R3", "R6", "R3");
        // R5: delay port write disturbs nothing
        step(16'h0080, 1, 0, 8'h00, 0); compare("R5", "R5", "R10");
        step(16'h0080, 1, 0, 8'hFF, 0); compare("R5", "R5", "R10");
        // R6: error raises and holds
        step(16'h0000, 0, 0, 8'h00, 1); compare("R5", "R6", "R10");
        step(16'h0000, 0, 0, 8'h00, 0); compare("R5", "R6", "R10");
        step(16'h0080, 1, 0, 8'h5A, 0); compare("R5", "R5", "R10");
        // R7: clear with arbitrary data
        step(16'h00F0, 1, 0, 8'hA5, 0); compare("R5", "R7", "R10");
        step(16'h00F0, 1, 0, 8'h00, 0); compare("R5", "R7", "R10");
        // R8: set and clear together
        step(16'h00F0, 1, 0, 8'h00, 1); compare("R5", "R8", "R10");
        step(16'h00F0, 1, 0, 8'h00, 0); compare("R5", "R7", "R10");
        // R9: reads of other ports
        step(16'h0080, 0, 1, 8'h00, 0); compare("R5", "R7", "R9");
        step(16'h00F0, 0, 1, 8'h00, 0); compare("R5", "R7", "R9");
        step(16'h0192, 0, 1, 8'h00, 0); compare("R5", "R7", "R9");
        // R10: idle cycle
        step(16'h0092, 0, 0, 8'hFF, 0); compare("R5", "R7", "R10");

        // random mix
        for (int i = 0; i < 600; i++) begin
            bit [15:0] a;
            bit [2:0]  sel = 3'($urandom_range(0, 5));
            case (sel)
                3'd0, 3'd1: a = 16'h0092;
                3'd2:       a = 16'h0080;
                3'd3:       a = 16'h00F0;
                default:    a = 16'($urandom);
            endcase
            step(a, 1'($urandom), 1'($urandom), 8'($urandom),
                 ($urandom_range(0, 7) == 0));
            compare("R2", "R6", "R3");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule